// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block evaluates one of seven comparison predicates on two single-precision operands. It returns a one-bit boolean answer and an invalid-operation flag. The predicates cover the unordered test, equality, less-than and less-or-equal. Each comes in an ordered form, and equality, less-than and less-or-equal also come in an unordered-inclusive form. It is fully combinational: the answer follows the operands and the predicate code with no clock.

The result of each predicate is defined when one or both operands are NaN. The two ordered relational predicates (less-than and less-or-equal) are signalling, so any NaN raises invalid. All other predicates are quiet and raise invalid only for a signalling NaN. Plus zero and minus zero compare equal. A control path uses the result for a branch condition or a boolean register write, and ORs the flag into its exception state.

Top module: `fcmp_predicate_unit`

## Requirements
- R1: Predicate code 0 (unordered) returns 1 exactly when at least one operand is NaN. A NaN has all exponent bits [30:23] set and a non-zero fraction [22:0].
- R2: Code 1 (ordered equal) returns 1 only when neither operand is NaN and the two values are equal.
- R3: Code 2 (unordered or equal) returns 1 when the values are equal or when either operand is NaN.
- R4: Code 3 (ordered less-than) returns 1 when a < b and neither operand is NaN. It returns 0 for any NaN.
- R5: Code 4 (unordered or less-than) returns 1 when a < b or when either operand is NaN.
- R6: Code 5 (ordered less-or-equal) returns 1 when a <= b and neither operand is NaN. It returns 0 for any NaN.
- R7: Code 6 (unordered or less-or-equal) returns 0 only when a > b, so it is 1 for unordered operands.
- R8: Code 7 is reserved: the result and invalid are both 0 for every operand pair.
- R9: +0 and -0 compare equal, and neither is less than the other.
- R10: Codes 0, 1, 2, 4 and 6 are quiet. They raise invalid only when an operand is a signalling NaN, which is a NaN with fraction bit 22 clear. A quiet NaN has bit 22 set and raises nothing.
- R11: Codes 3 and 5 are signalling: they raise invalid whenever either operand is any NaN.
- R12: Ordering of non-NaN values is by real value. Negative values order below positive ones, larger magnitudes order below smaller ones among negatives, and infinities are the extremes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand, single precision (sign 31, exponent 30:23, fraction 22:0) |
| op_b | input | 32 | Second operand, same format |
| pred_sel | input | 3 | Predicate code 0..7 as listed in the requirements |
| result | output | 1 | Boolean predicate outcome |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The unit holds no state, so any fault in the NaN classifier or the magnitude order shows at the ports within the same evaluation as the inputs that reach it. A misclassified signalling NaN shows up as a missing or spurious invalid flag on a quiet predicate. A wrong sign-reversed order flips less-than for negative pairs. Random operands are weighted towards zeros, infinities, both NaN kinds and values of close magnitude, so these faults appear under many predicate codes. Directed vectors pin the signed-zero, reserved-code and NaN-class corners.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [2:0] {
        PRED_UN  = 3'd0,
        PRED_OEQ = 3'd1,
        PRED_UEQ = 3'd2,
        PRED_OLT = 3'd3,
        PRED_ULT = 3'd4,
        PRED_OLE = 3'd5,
        PRED_ULE = 3'd6,
        PRED_RSV = 3'd7
    } pred_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } opclass_t;

    typedef struct packed {
        logic result;
        logic invalid;
    } cmp_out_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]   operand,
    output opclass_t               cls,
    output logic [EXP_W+MAN_W-1:0] mag
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             man_nz;

    always_comb begin
        exp_f       = operand[MAG_W-1:MAN_W];
        man_f       = operand[MAN_W-1:0];
        exp_ones    = &exp_f;
        man_nz      = |man_f;
        mag         = operand[MAG_W-1:0];
        cls.sign    = operand[MAG_W];
        cls.is_zero = ~|operand[MAG_W-1:0];
        cls.is_nan  = exp_ones & man_nz;
        // quiet bit is the fraction MSB
        cls.is_snan = exp_ones & man_nz & ~man_f[MAN_W-1];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  opclass_t         cls_a,
    input  opclass_t         cls_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output logic             eq_raw,
    output logic             lt_raw
);
    logic both_zero;
    logic mag_eq;
    logic mag_lt;

    always_comb begin
        both_zero = cls_a.is_zero & cls_b.is_zero;
        mag_eq    = (mag_a == mag_b);
        mag_lt    = (mag_a < mag_b);
        eq_raw    = both_zero | ((cls_a.sign == cls_b.sign) & mag_eq);
        if (both_zero) begin
            lt_raw = 1'b0;
        end else if (cls_a.sign != cls_b.sign) begin
            lt_raw = cls_a.sign;
        end else if (cls_a.sign) begin
            lt_raw = ~mag_lt & ~mag_eq;
        end else begin
            lt_raw = mag_lt;
        end
    end
endmodule

// File: rtl/fcmp_select.sv
module fcmp_select
    import fcmp_pkg::*;
(
    input  logic [2:0] pred_sel,
    input  logic       unord,
    input  logic       any_snan,
    input  logic       eq_raw,
    input  logic       lt_raw,
    output cmp_out_t   out_d
);
    logic eq_ord;
    logic lt_ord;

    always_comb begin
        eq_ord = eq_raw & ~unord;
        lt_ord = lt_raw & ~unord;
        out_d  = '0;
        unique case (pred_e'(pred_sel))
            PRED_UN:  out_d = '{result: unord,                   invalid: any_snan};
            PRED_OEQ: out_d = '{result: eq_ord,                  invalid: any_snan};
            PRED_UEQ: out_d = '{result: eq_ord | unord,          invalid: any_snan};
            PRED_OLT: out_d = '{result: lt_ord,                  invalid: unord};
            PRED_ULT: out_d = '{result: lt_ord | unord,          invalid: any_snan};
            PRED_OLE: out_d = '{result: lt_ord | eq_ord,         invalid: unord};
            PRED_ULE: out_d = '{result: lt_ord | eq_ord | unord, invalid: any_snan};
            default:  out_d = '0;
        endcase
    end
endmodule

// File: rtl/fcmp_predicate_unit.sv
module fcmp_predicate_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic [2:0]           pred_sel,
    output logic                 result,
    output logic                 invalid
);
    localparam int MAG_W = EXP_W + MAN_W;
    localparam int OP_W  = MAG_W + 1;
    localparam int N_OPS = 2;

    logic [N_OPS-1:0][OP_W-1:0]  ops;
    opclass_t                    cls  [N_OPS];
    logic [MAG_W-1:0]            mags [N_OPS];
    logic                        unord;
    logic                        any_snan;
    logic                        eq_raw;
    logic                        lt_raw;
    cmp_out_t                    out_d;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .operand (ops[gi]),
            .cls     (cls[gi]),
            .mag     (mags[gi])
        );
    end

    always_comb begin
        unord    = cls[0].is_nan  | cls[1].is_nan;
        any_snan = cls[0].is_snan | cls[1].is_snan;
    end

    fcmp_order #(.MAG_W(MAG_W)) u_order (
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .mag_a  (mags[0]),
        .mag_b  (mags[1]),
        .eq_raw (eq_raw),
        .lt_raw (lt_raw)
    );

    fcmp_select u_sel (
        .pred_sel (pred_sel),
        .unord    (unord),
        .any_snan (any_snan),
        .eq_raw   (eq_raw),
        .lt_raw   (lt_raw),
        .out_d    (out_d)
    );

    assign result  = out_d.result;
    assign invalid = out_d.invalid;
endmodule

// File: rtl/fcmp_predicate_checker.sv
module fcmp_predicate_checker (
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [2:0]  pred_sel,
    input logic        result,
    input logic        invalid
);
    logic nan_a, nan_b, nan_any, sn_any, zz;

    always_comb begin
        nan_a   = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 23'd0);
        nan_b   = (op_b[30:23] == 8'hFF) && (op_b[22:0] != 23'd0);
        nan_any = nan_a || nan_b;
        sn_any  = (nan_a && !op_a[22]) || (nan_b && !op_b[22]);
        zz      = (op_a[30:0] == 31'd0) && (op_b[30:0] == 31'd0);

        AST_RESERVED_SILENT: assert (pred_sel != 3'd7 || (!result && !invalid)); // R8
        AST_UN_MATCHES_NAN: assert (pred_sel != 3'd0 || result == nan_any); // R1
        AST_UNORD_FORMS_TRUE: assert (!nan_any || !(pred_sel == 3'd2 || pred_sel == 3'd4 || pred_sel == 3'd6) || result); // R7
        AST_ORDERED_NAN_FALSE: assert (!nan_any || !(pred_sel == 3'd1 || pred_sel == 3'd3 || pred_sel == 3'd5) || !result); // R4
        AST_SIGNALLING_INVALID: assert (!(pred_sel == 3'd3 || pred_sel == 3'd5) || invalid == nan_any); // R11
        AST_QUIET_INVALID: assert ((pred_sel == 3'd3 || pred_sel == 3'd5 || pred_sel == 3'd7) || invalid == sn_any); // R10
        AST_ZERO_EQUAL: assert (!zz || pred_sel != 3'd1 || result); // R9
    end
endmodule

bind fcmp_predicate_unit fcmp_predicate_checker u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .pred_sel (pred_sel),
    .result   (result),
    .invalid  (invalid)
);

// File: tb/fcmp_predicate_unit_bench.sv
module fcmp_predicate_unit_bench;
    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [2:0]  sel;
    logic        res, inv;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    fcmp_predicate_unit u_fcmp_predicate_unit (
        .op_a(a), .op_b(b), .pred_sel(sel), .result(res), .invalid(inv)
    );

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic longint okey(input logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic void ref_eval(input logic [31:0] x, y, input logic [2:0] s,
                                     output logic r, output logic v);
        bit un = is_nan(x) || is_nan(y);
        bit sn = (is_nan(x) && !x[22]) || (is_nan(y) && !y[22]);
        bit eq = !un && okey(x) == okey(y);
        bit lt = !un && okey(x) <  okey(y);
        case (s)
            3'd0: begin r = un;             v = sn; end
            3'd1: begin r = eq;             v = sn; end
            3'd2: begin r = eq || un;       v = sn; end
            3'd3: begin r = lt;             v = un; end
            3'd4: begin r = lt || un;       v = sn; end
            3'd5: begin r = lt || eq;       v = un; end
            3'd6: begin r = lt || eq || un; v = sn; end
            default: begin r = 0;           v = 0;  end
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0: return "R1";  3'd1: return "R2";  3'd2: return "R3";
            3'd3: return "R4";  3'd4: return "R5";  3'd5: return "R6";
            3'd6: return "R7";  default: return "R8";
        endcase
    endfunction

    task automatic run(input logic [31:0] x, y, input logic [2:0] s, input string tag);
        logic er, ev;
        @(posedge clk);
        a = x; b = y; sel = s;
        @(negedge clk);
        ref_eval(x, y, s, er, ev);
        checks++;
        if (res !== er || inv !== ev) begin
            errors++;
            $display("FAIL %s a=%h b=%h sel=%0d got res=%b inv=%b exp res=%b inv=%b",
                     tag, x, y, s, res, inv, er, ev);
        end
    endtask

    function automatic logic [31:0] pick(input int unsigned r);
        logic [31:0] base = 32'h3F80_0000 + (r & 32'h3);
        case (r % 10)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return {r[31], 8'hFF, 1'b1, r[22:1] | 22'd0};
            5: return {r[31], 8'hFF, 1'b0, r[21:0] | 22'd1};
            6: return {r[31], base[30:0]};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        a = 0; b = 0; sel = 3'd7;
        // idle state: reserved code silent
        run(32'h0, 32'h0, 3'd7, "R8");
        run(32'h7FC0_0000, 32'h7F80_0001, 3'd7, "R8");
        // signed zero
        run(32'h0000_0000, 32'h8000_0000, 3'd1, "R9");
        run(32'h8000_0000, 32'h0000_0000, 3'd3, "R9");
        run(32'h8000_0000, 32'h0000_0000, 3'd5, "R9");
        // ordering across signs and among negatives
        run(32'hBF80_0000, 32'h3F80_0000, 3'd3, "R12");
        run(32'hC000_0000, 32'hBF80_0000, 3'd3, "R12");
        run(32'hBF80_0000, 32'hC000_0000, 3'd3, "R12");
        run(32'hFF80_0000, 32'hFF7F_FFFF, 3'd3, "R12");
        run(32'h7F80_0000, 32'h7F7F_FFFF, 3'd6, "R12");
        // NaN classes
        run(32'h7FC0_0000, 32'h3F80_0000, 3'd3, "R11");
        run(32'h7FC0_0000, 32'h3F80_0000, 3'd5, "R11");
        run(32'h7FC0_0000, 32'h3F80_0000, 3'd2, "R10");
        run(32'h7F80_0001, 32'h3F80_0000, 3'd2, "R10");
        run(32'h3F80_0000, 32'hFFA0_0000, 3'd0, "R10");
        run(32'h7FC0_0000, 32'h7FC0_0000, 3'd6, "R7");
        run(32'h7FC0_0000, 32'h7FC0_0000, 3'd1, "R2");
        run(32'hFFC0_0000, 32'h0000_0000, 3'd4, "R5");
        run(32'h4000_0000, 32'h4000_0000, 3'd6, "R7");
        run(32'h4000_0001, 32'h4000_0000, 3'd6, "R7");
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] s = 3'($urandom);
            run(pick($urandom), pick($urandom), s, tag_of(s));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule